// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block runs on the controller side of a DDR SDRAM interface. It takes over the command pins from reset and walks the memory through its bring-up. First it waits with the clock enable held low. It then raises the clock enable and issues a precharge of every bank. Next come two mode register loads: the first turns on the delay-locked loop and the second resets it while setting the operating mode. A second precharge of every bank follows, then two refresh cycles, and finally a mode register load with the DLL-reset bit cleared. Once all of this is done and the DLL has had time to lock, it raises a ready flag. After that the normal controller may take the pins.

The clock frequency is a parameter. The power-up wait and the precharge and refresh recovery times are converted from time to clock cycles inside the block. The mode register settings and the extended mode register settings are also parameters. The clock is assumed stable when reset is released.

Top module: `ddr_init_seq`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cke` is 0, `init_done` is 0, `ba` and `addr` are 0, and the command pins {cs_n,ras_n,cas_n,we_n} show NOP = 4'b0111.
- R2: `cke` stays low for at least CLK_MHZ*PWRUP_US cycles after reset is released. The command pins show only NOP while `cke` is low.
- R3: After the wait, `cke` goes high with NOP on the pins. The first command other than NOP is a precharge of all banks: pins 4'b0010, `addr[10]`=1, `ba`=0.
- R4: The second command is a mode register load (4'b0000) with `ba`=2'b01 and `addr` equal to EMR_VAL.
- R5: The third command is a mode register load with `ba`=2'b00 and `addr` equal to MR_VAL with bit DLL_RST_BIT (default 8) set.
- R6: The fourth command is another precharge of all banks (4'b0010, `addr[10]`=1).
- R7: The fifth and sixth commands are refreshes (4'b0001, `addr`=0, `ba`=0). Each one is followed by at least ceil(TRFC_NS*CLK_MHZ/1000) cycles before the next command or before `init_done`.
- R8: The seventh and last command is a mode register load with `ba`=2'b00 and `addr` equal to MR_VAL with bit DLL_RST_BIT cleared. No other command appears.
- R9: Each precharge is followed by at least ceil(TRP_NS*CLK_MHZ/1000) cycles, and each mode register load by at least TMRD_CYC cycles, before the next command or before `init_done`.
- R10: `init_done` rises at least DLL_LOCK_CYC cycles after the DLL-reset load appears on the pins. It rises only after all seven commands, then stays high while the pins show NOP with `cke` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, assumed stable at reset release |
| rst | input | 1 | Synchronous active-high reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address / mode register select |
| addr | output | 13 | Address bus / mode register payload |
| init_done | output | 1 | High once normal traffic may start |

## Verification
The assertions assume that `rst` is held high for at least one clock edge before any check matters, and that `rst` is the only input the block has. After that, every property follows from the sequencer's own progress. The timer properties assume that a load never coincides with the counter's reset value being invalid, and the DLL property assumes the lock counter is started exactly once. The stimulus respects both: it pulses reset once at the start and then lets the sequence run untouched to completion and beyond.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  localparam int ADDR_W = 13;
  localparam int BA_W   = 2;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } ddr_cmd_e;

  // order is the bring-up order; the sequencer advances by increment
  typedef enum logic [3:0] {
    ST_PWR   = 4'd0,
    ST_CKE   = 4'd1,
    ST_PRE1  = 4'd2,
    ST_EMR   = 4'd3,
    ST_MRDLL = 4'd4,
    ST_PRE2  = 4'd5,
    ST_REF1  = 4'd6,
    ST_REF2  = 4'd7,
    ST_MRRUN = 4'd8,
    ST_HOLD  = 4'd9,
    ST_DONE  = 4'd10
  } init_step_e;

  typedef struct packed {
    ddr_cmd_e          cmd;
    logic [BA_W-1:0]   ba;
    logic [ADDR_W-1:0] addr;
  } cmd_word_t;

  function automatic int ns_to_cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int at_least2(input int v);
    return (v < 2) ? 2 : v;
  endfunction

endpackage

// File: rtl/ddr_wait_timer.sv
module ddr_wait_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_VAL = 100
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= CNT_W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (expired && !load) |=> expired);

  // R9
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!expired && !load) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/ddr_dll_timer.sv
module ddr_dll_timer #(
  parameter int LOCK_CYC = 200
)(
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic locked
);

  localparam int LW = $clog2(LOCK_CYC + 1);

  logic [LW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (start) begin
      cnt   <= LW'(LOCK_CYC);
      armed <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign locked = armed && (cnt == '0);

  // R10
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && !start) |=> locked);

  // R10
  start_unlocks_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> !locked);

endmodule

// File: rtl/ddr_cmd_drive.sv
module ddr_cmd_drive import ddr_init_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_en,
  input  cmd_word_t         word,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cke   <= 1'b0;
      cs_n  <= 1'b0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
      we_n  <= 1'b1;
      ba    <= '0;
      addr  <= '0;
    end else begin
      cke                       <= cke_en;
      {cs_n, ras_n, cas_n, we_n} <= word.cmd;
      ba                        <= word.ba;
      addr                      <= word.addr;
    end
  end

  // R2
  cke_low_nop_chk: assert property (@(posedge clk) disable iff (rst)
    !cke |-> ({cs_n, ras_n, cas_n, we_n} == CMD_NOP));

  // R3
  pre_all_banks_chk: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == CMD_PRE) |-> addr[10]);

  // R2
  cke_no_drop_chk: assert property (@(posedge clk) disable iff (rst)
    cke |=> cke);

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq import ddr_init_pkg::*; #(
  parameter int                CLK_MHZ      = 200,
  parameter int                PWRUP_US     = 200,
  parameter int                TRP_NS       = 15,
  parameter int                TRFC_NS      = 75,
  parameter int                TMRD_CYC     = 2,
  parameter int                DLL_LOCK_CYC = 200,
  parameter int                DLL_RST_BIT  = 8,
  parameter logic [ADDR_W-1:0] MR_VAL       = 13'h032,
  parameter logic [ADDR_W-1:0] EMR_VAL      = 13'h000
)(
  input  logic              clk,
  input  logic              rst,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int PWR_CYC = CLK_MHZ * PWRUP_US;
  localparam int RP_CYC  = at_least2(ns_to_cyc(TRP_NS, CLK_MHZ));
  localparam int RFC_CYC = at_least2(ns_to_cyc(TRFC_NS, CLK_MHZ));
  localparam int MRD_CYC = at_least2(TMRD_CYC);
  localparam int CNT_W   = $clog2(PWR_CYC + RFC_CYC + RP_CYC + MRD_CYC + 1);

  localparam logic [ADDR_W-1:0] DLL_MASK = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] PRE_ALL  = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] MR_RESET = MR_VAL | DLL_MASK;
  localparam logic [ADDR_W-1:0] MR_RUN   = MR_VAL & ~DLL_MASK;

  init_step_e       step;
  logic             issued;
  logic             adv;
  logic             ld;
  logic [CNT_W-1:0] ld_val;
  logic             expired;
  logic             dll_start;
  logic             dll_locked;
  cmd_word_t        word;

  function automatic logic is_cmd_step(input init_step_e s);
    return (s != ST_PWR) && (s != ST_HOLD) && (s != ST_DONE);
  endfunction

  function automatic cmd_word_t word_of(input init_step_e s);
    cmd_word_t w;
    w = '{cmd: CMD_NOP, ba: '0, addr: '0};
    case (s)
      ST_PRE1, ST_PRE2: w = '{cmd: CMD_PRE, ba: '0,     addr: PRE_ALL};
      ST_EMR:           w = '{cmd: CMD_LMR, ba: 2'b01,  addr: EMR_VAL};
      ST_MRDLL:         w = '{cmd: CMD_LMR, ba: 2'b00,  addr: MR_RESET};
      ST_REF1, ST_REF2: w = '{cmd: CMD_REF, ba: '0,     addr: '0};
      ST_MRRUN:         w = '{cmd: CMD_LMR, ba: 2'b00,  addr: MR_RUN};
      default:          w = '{cmd: CMD_NOP, ba: '0,     addr: '0};
    endcase
    return w;
  endfunction

  // spacing to the next step, minus the two cycles the handshake adds
  function automatic logic [CNT_W-1:0] hold_of(input init_step_e s);
    int g;
    case (s)
      ST_PRE1, ST_PRE2:          g = RP_CYC;
      ST_EMR, ST_MRDLL, ST_MRRUN: g = MRD_CYC;
      ST_REF1, ST_REF2:          g = RFC_CYC;
      default:                   g = 2;
    endcase
    return CNT_W'(g - 2);
  endfunction

  always_comb begin
    word      = word_of(ST_PWR);
    ld        = 1'b0;
    ld_val    = '0;
    dll_start = 1'b0;
    adv       = 1'b0;
    if (step == ST_PWR) begin
      adv = expired;
    end else if (step == ST_HOLD) begin
      adv = dll_locked;
    end else if (is_cmd_step(step)) begin
      if (!issued) begin
        word      = word_of(step);
        ld        = 1'b1;
        ld_val    = hold_of(step);
        dll_start = (step == ST_MRDLL);
      end else begin
        adv = expired;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step      <= ST_PWR;
      issued    <= 1'b1;
      init_done <= 1'b0;
    end else begin
      init_done <= (step == ST_DONE);
      if (adv) begin
        step   <= init_step_e'(step + 4'd1);
        issued <= 1'b0;
      end else if (is_cmd_step(step)) begin
        issued <= 1'b1;
      end
    end
  end

  ddr_wait_timer #(
    .CNT_W   (CNT_W),
    .RST_VAL (PWR_CYC - 1)
  ) u_wait (
    .clk      (clk),
    .rst      (rst),
    .load     (ld),
    .load_val (ld_val),
    .expired  (expired)
  );

  ddr_dll_timer #(
    .LOCK_CYC (DLL_LOCK_CYC)
  ) u_dll (
    .clk    (clk),
    .rst    (rst),
    .start  (dll_start),
    .locked (dll_locked)
  );

  ddr_cmd_drive u_drive (
    .clk    (clk),
    .rst    (rst),
    .cke_en (step != ST_PWR),
    .word   (word),
    .cke    (cke),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .ba     (ba),
    .addr   (addr)
  );

  // R10
  done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  // R10
  done_after_lock_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |-> dll_locked);

  // R10
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (cke && {cs_n, ras_n, cas_n, we_n} == CMD_NOP));

  // R2
  wait_before_cke_chk: assert property (@(posedge clk) disable iff (rst)
    (step == ST_PWR) |=> !cke);

  // R5
  dll_start_once_chk: assert property (@(posedge clk) disable iff (rst)
    dll_start |=> !dll_start);

endmodule

// File: tb/sim_ddr_init_seq.sv
module sim_ddr_init_seq;

  localparam int PWR_CYC  = 200 * 200;
  localparam int RP_CYC   = 3;
  localparam int RFC_CYC  = 15;
  localparam int MRD_CYC  = 2;
  localparam int DLL_CYC  = 200;
  localparam logic [12:0] MR_VAL  = 13'h032;
  localparam logic [12:0] EMR_VAL = 13'h000;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, LMR = 4'b0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0]  ba;
  logic [12:0] addr;

  always #2.5 clk = ~clk;

  ddr_init_seq u0 (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .init_done(init_done)
  );

  typedef struct {
    logic [3:0]  cmd;
    logic [1:0]  ba;
    logic [12:0] addr;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] c, input logic [1:0] b,
                      input logic [12:0] a, input string tag);
    exp_t e;
    e.cmd = c; e.ba = b; e.addr = a; e.tag = tag;
    q.push_back(e);
  endtask

  function automatic int need_of(input logic [3:0] c);
    if (c == PRE) return RP_CYC;
    if (c == REF) return RFC_CYC;
    return MRD_CYC;
  endfunction

  // monitor / scoreboard
  int cyc = 0, low_cnt = 0, last_t = -1, last_need = 0, dll_t = -1, done_cyc = 0;
  logic [3:0] last_cmd = NOP;
  bit cke_seen = 0, done_seen = 0;

  always @(negedge clk) begin
    if (!rst) begin
      logic [3:0] c;
      exp_t e;
      cyc++;
      c = {cs_n, ras_n, cas_n, we_n};
      if (!cke) begin
        low_cnt++;
        if (c != NOP) chk(0, "R2", "command while cke low", c, NOP);
      end else if (!cke_seen) begin
        cke_seen = 1;
        chk(low_cnt >= PWR_CYC, "R2", "cke low cycles", low_cnt, PWR_CYC);
        chk(c == NOP, "R3", "pins at cke rise", c, NOP);
      end
      if (c != NOP) begin
        if (q.size() == 0) begin
          chk(0, "R8", "extra command", c, NOP);
        end else begin
          e = q.pop_front();
          chk(c == e.cmd, e.tag, "command code", c, e.cmd);
          chk(ba == e.ba, e.tag, "bank field", ba, e.ba);
          chk(addr == e.addr, e.tag, "address field", addr, e.addr);
        end
        if (last_t >= 0)
          chk(cyc - last_t >= last_need, (last_cmd == REF) ? "R7" : "R9",
              "command spacing", cyc - last_t, last_need);
        last_t    = cyc;
        last_cmd  = c;
        last_need = need_of(c);
        if (c == LMR && ba == 2'b00 && addr[8]) dll_t = cyc;
      end
      if (init_done && !done_seen) begin
        done_seen = 1;
        done_cyc  = cyc;
        chk(q.size() == 0, "R10", "commands left at done", q.size(), 0);
        chk(dll_t >= 0 && cyc - dll_t >= DLL_CYC, "R10", "dll lock span",
            cyc - dll_t, DLL_CYC);
        chk(cyc - last_t >= last_need, (last_cmd == REF) ? "R7" : "R9",
            "spacing before done", cyc - last_t, last_need);
      end else if (done_seen) begin
        chk(init_done, "R10", "done stays high", init_done, 1);
        chk(c == NOP && cke, "R10", "idle after done", c, NOP);
      end
    end
  end

  initial begin
    push(PRE, 2'b00, 13'h0400, "R3");
    push(LMR, 2'b01, EMR_VAL, "R4");
    push(LMR, 2'b00, MR_VAL | 13'h0100, "R5");
    push(PRE, 2'b00, 13'h0400, "R6");
    push(REF, 2'b00, 13'h0000, "R7");
    push(REF, 2'b00, 13'h0000, "R7");
    push(LMR, 2'b00, MR_VAL & ~13'h0100, "R8");

    repeat (4) @(negedge clk);
    // R1 reset state
    chk(cke == 1'b0, "R1", "cke in reset", cke, 0);
    chk({cs_n, ras_n, cas_n, we_n} == NOP, "R1", "command in reset",
        {cs_n, ras_n, cas_n, we_n}, NOP);
    chk(init_done == 1'b0, "R1", "done in reset", init_done, 0);
    chk(ba == 2'b00 && addr == 13'h0, "R1", "address in reset", addr, 0);
    #1 rst = 1'b0;
    @(negedge clk);
    #1;
    chk(cke == 1'b0 && init_done == 1'b0, "R1", "first cycle after reset", cke, 0);

    for (int i = 0; i < PWR_CYC + 5000 && !init_done; i++) @(negedge clk);
    if (!init_done) chk(0, "R10", "watchdog expired before done", 0, 1);
    else repeat (50) @(negedge clk);
    #1;
    chk(q.size() == 0, "R8", "all seven commands seen", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule